// File: doc/BRIEF.md
# Processor Fault Entry Sequencer

This block sits beside a processor core's control unit. When the core reports a fault, it sends a one-cycle request with three items: a raw fault number, a subtype word and the kind of cycle it was in (fetch, execute, fault-execute or any other). On that clock edge the sequencer records the state that the fault service routine needs. It registers the fault number and subtype, steps a small rolling counter held in the low bits of a wider cycle-bits register, and replaces the access-violation status flags with the ones the subtype selects. It also records the connect channel, marks whether the fault hit a fetch, and accumulates illegal-procedure causes into a sticky fault register.

A fault can arrive while the core is already in the fault-execute cycle, which means the fault handler itself faulted. The sequencer then substitutes the trouble fault and zeroes the subtype. A trouble-cycle flag remembers that this happened. A second nested fault while that flag is set raises a cascade-halt pulse. Each accepted request produces a one-cycle entry pulse that tells the core to move to the fault cycle. The sequencer also counts instructions that ended in a fault during their execute cycle.

Top module: `fault_entry_seq`

## Requirements
- R1: While reset is held, and after it is released, every output is zero except `cycle_bits`, which holds the parameter value `CB_INIT` (default 0xA50).
- R2: A raw fault number with any bit set above bit 4 is replaced by fault number 31. A number in range is registered unchanged in `fault_num_q`.
- R3: Each accepted request adds one, modulo 8, to `cycle_bits[2:0]`. Bits above bit 2 never change.
- R4: For fault number 20 (access violation), bit i of the registered subtype sets `acv_flags[i]` for every i. Any other accepted fault leaves `acv_flags` all zero.
- R5: `fetch_flag` is set by a fault taken in the fetch cycle (cycle code 2'b00) and cleared by a fault taken in any other cycle. `fault_sub_q` holds the subtype of the last accepted fault.
- R6: For fault number 8 (connect), `chan_num` takes subtype bits [2:0]. For every other fault `chan_num` is zero.
- R7: A fault taken in the fault-execute cycle (code 2'b10) is registered as number 31 with subtype zero. It sets no access-violation flag and no channel, and it sets `trouble_flag`.
- R8: If a fault arrives in the fault-execute cycle while `trouble_flag` is already set, `cascade_halt` is high for exactly the one cycle after that edge.
- R9: A fault taken in any cycle other than fault-execute clears `trouble_flag`. The `trouble_clr` input clears it too, unless a request arrives on the same edge, in which case the request decides.
- R10: For fault number 10 (illegal procedure), the subtype is OR-ed into `fault_reg`. No other fault changes `fault_reg`.
- R11: `instr_cnt` increases by one for each fault taken in the execute cycle (code 2'b01). `enter_fault` is high for exactly the cycle after each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_req | input | 1 | One-cycle fault request |
| flt_num | input | NUM_W (7) | Raw fault number |
| flt_sub | input | SUB_W (16) | Fault subtype word |
| flt_cyc | input | 2 | Cycle kind: 00 fetch, 01 execute, 10 fault-execute, 11 other |
| trouble_clr | input | 1 | Clears the trouble-cycle flag |
| enter_fault | output | 1 | Pulse: enter the fault cycle |
| fault_num_q | output | 5 | Registered effective fault number (also the fault address field) |
| fault_sub_q | output | SUB_W | Registered effective subtype |
| fetch_flag | output | 1 | Fault occurred during fetch |
| chan_num | output | 3 | Connect channel number |
| acv_flags | output | SUB_W | Access-violation cause flags |
| fault_reg | output | SUB_W | Sticky illegal-procedure cause register |
| cycle_bits | output | CB_W (12) | Cycle-bits register with mod-8 counter in bits [2:0] |
| instr_cnt | output | CNT_W (16) | Count of faults taken in execute |
| trouble_flag | output | 1 | A fault was taken in fault-execute |
| cascade_halt | output | 1 | Pulse: nested fault while trouble flag set |

## Verification
The embedded assertions check several properties on every cycle. The counter field must step by exactly one per request while the upper bits hold, and the entry pulse must follow each request and nothing else. A halt may only come from a trouble flag that was already set. A non-nested fault must clear the flag, the channel must stay zero for non-connect faults, and the illegal-procedure register may only gain bits. The directed scenarios cover what depends on specific values. These include clamping of out-of-range numbers, the exact mapping of subtype bits to access-violation flags, and the substitution of the trouble fault. They also cover the first-versus-second nested fault distinction, the priority of a request over a clear, and counter wrap-around.

// File: rtl/fault_entry_pkg.sv
package fault_entry_pkg;

    localparam int unsigned FN_W = 5;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_EXEC  = 2'b01,
        CYC_FEXEC = 2'b10,
        CYC_OTHER = 2'b11
    } cyc_e;

    localparam logic [FN_W-1:0] FN_CONNECT = 5'd8;
    localparam logic [FN_W-1:0] FN_ILLPROC = 5'd10;
    localparam logic [FN_W-1:0] FN_ACCVIO  = 5'd20;
    localparam logic [FN_W-1:0] FN_TROUBLE = 5'd31;

    typedef struct packed {
        logic [FN_W-1:0] num;
        logic            in_fetch;
        logic            in_exec;
        logic            in_fexec;
    } fault_hdr_t;

    function automatic logic is_num(input logic [FN_W-1:0] a, input logic [FN_W-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/fe_decode.sv
module fe_decode
    import fault_entry_pkg::*;
#(
    parameter int unsigned NUM_W = 7,
    parameter int unsigned SUB_W = 16
) (
    input  logic [NUM_W-1:0] raw_num,
    input  logic [SUB_W-1:0] raw_sub,
    input  logic [1:0]       cyc,
    output fault_hdr_t       hdr,
    output logic [SUB_W-1:0] eff_sub,
    output logic [SUB_W-1:0] acv_next,
    output logic [2:0]       chan_next
);
    logic out_of_range;
    logic [FN_W-1:0] clamped;
    cyc_e cyc_k;

    generate
        if (NUM_W > FN_W) begin : g_wide
            assign out_of_range = |raw_num[NUM_W-1:FN_W];
        end else begin : g_narrow
            assign out_of_range = 1'b0;
        end
    endgenerate

    always_comb begin
        cyc_k        = cyc_e'(cyc);
        clamped      = out_of_range ? FN_TROUBLE : raw_num[FN_W-1:0];
        hdr.in_fetch = (cyc_k == CYC_FETCH);
        hdr.in_exec  = (cyc_k == CYC_EXEC);
        hdr.in_fexec = (cyc_k == CYC_FEXEC);
        hdr.num      = hdr.in_fexec ? FN_TROUBLE : clamped;
        eff_sub      = hdr.in_fexec ? '0 : raw_sub;
        acv_next     = is_num(hdr.num, FN_ACCVIO) ? eff_sub : '0;
        chan_next    = is_num(hdr.num, FN_CONNECT) ? eff_sub[2:0] : 3'd0;
    end
endmodule

// File: rtl/fe_trouble.sv
module fe_trouble (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic in_fexec,
    input  logic clr,
    output logic flag,
    output logic halt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            halt <= 1'b0;
        end else begin
            halt <= req && in_fexec && flag;
            if (req)      flag <= in_fexec;
            else if (clr) flag <= 1'b0;
        end
    end

    a_r8_halt_from_set_flag: assert property (@(posedge clk) disable iff (rst)
        halt |-> ($past(flag) && flag));
    a_r9_plain_fault_clears: assert property (@(posedge clk) disable iff (rst)
        (req && !in_fexec) |=> !flag);
    a_r7_nested_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (req && in_fexec) |=> flag);
endmodule

// File: rtl/fe_counters.sv
module fe_counters #(
    parameter int unsigned      CB_W    = 12,
    parameter logic [CB_W-1:0]  CB_INIT = 12'hA50,
    parameter int unsigned      CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             in_exec,
    output logic [CB_W-1:0]  cycle_bits,
    output logic [CNT_W-1:0] instr_cnt
);
    localparam int unsigned LOW_W = 3;

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_bits <= CB_INIT;
            instr_cnt  <= '0;
        end else if (req) begin
            cycle_bits[LOW_W-1:0] <= cycle_bits[LOW_W-1:0] + 3'd1;
            if (in_exec) instr_cnt <= instr_cnt + 1'b1;
        end
    end

    a_r3_low_steps: assert property (@(posedge clk) disable iff (rst)
        req |=> (cycle_bits[LOW_W-1:0] == $past(cycle_bits[LOW_W-1:0]) + 3'd1));
    a_r3_upper_hold: assert property (@(posedge clk) disable iff (rst)
        $stable(cycle_bits[CB_W-1:LOW_W]));
    a_r11_count_only_exec: assert property (@(posedge clk) disable iff (rst)
        !(req && in_exec) |=> $stable(instr_cnt));
endmodule

// File: rtl/fault_entry_seq.sv
module fault_entry_seq
    import fault_entry_pkg::*;
#(
    parameter int unsigned     NUM_W   = 7,
    parameter int unsigned     SUB_W   = 16,
    parameter int unsigned     CB_W    = 12,
    parameter logic [CB_W-1:0] CB_INIT = 12'hA50,
    parameter int unsigned     CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flt_req,
    input  logic [NUM_W-1:0] flt_num,
    input  logic [SUB_W-1:0] flt_sub,
    input  logic [1:0]       flt_cyc,
    input  logic             trouble_clr,
    output logic             enter_fault,
    output logic [4:0]       fault_num_q,
    output logic [SUB_W-1:0] fault_sub_q,
    output logic             fetch_flag,
    output logic [2:0]       chan_num,
    output logic [SUB_W-1:0] acv_flags,
    output logic [SUB_W-1:0] fault_reg,
    output logic [CB_W-1:0]  cycle_bits,
    output logic [CNT_W-1:0] instr_cnt,
    output logic             trouble_flag,
    output logic             cascade_halt
);
    fault_hdr_t       hdr;
    logic [SUB_W-1:0] eff_sub;
    logic [SUB_W-1:0] acv_next;
    logic [2:0]       chan_next;

    fe_decode #(.NUM_W(NUM_W), .SUB_W(SUB_W)) u_decode (
        .raw_num  (flt_num),
        .raw_sub  (flt_sub),
        .cyc      (flt_cyc),
        .hdr      (hdr),
        .eff_sub  (eff_sub),
        .acv_next (acv_next),
        .chan_next(chan_next)
    );

    fe_trouble u_trouble (
        .clk     (clk),
        .rst     (rst),
        .req     (flt_req),
        .in_fexec(hdr.in_fexec),
        .clr     (trouble_clr),
        .flag    (trouble_flag),
        .halt    (cascade_halt)
    );

    fe_counters #(.CB_W(CB_W), .CB_INIT(CB_INIT), .CNT_W(CNT_W)) u_counters (
        .clk       (clk),
        .rst       (rst),
        .req       (flt_req),
        .in_exec   (hdr.in_exec),
        .cycle_bits(cycle_bits),
        .instr_cnt (instr_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enter_fault <= 1'b0;
            fault_num_q <= '0;
            fault_sub_q <= '0;
            fetch_flag  <= 1'b0;
            chan_num    <= '0;
            acv_flags   <= '0;
            fault_reg   <= '0;
        end else begin
            enter_fault <= flt_req;
            if (flt_req) begin
                fault_num_q <= hdr.num;
                fault_sub_q <= eff_sub;
                fetch_flag  <= hdr.in_fetch;
                chan_num    <= chan_next;
                acv_flags   <= acv_next;
                if (is_num(hdr.num, FN_ILLPROC)) fault_reg <= fault_reg | eff_sub;
            end
        end
    end

    a_r11_entry_follows_req: assert property (@(posedge clk) disable iff (rst)
        flt_req |=> enter_fault);
    a_r11_no_spurious_entry: assert property (@(posedge clk) disable iff (rst)
        !flt_req |=> !enter_fault);
    a_r6_chan_only_connect: assert property (@(posedge clk) disable iff (rst)
        (enter_fault && fault_num_q != FN_CONNECT) |-> (chan_num == 3'd0));
    a_r10_freg_only_grows: assert property (@(posedge clk) disable iff (rst)
        ((fault_reg & $past(fault_reg)) == $past(fault_reg)));
endmodule

// File: tb/fault_entry_seq_tb_top.sv
module fault_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flt_req = 1'b0;
    logic [6:0]  flt_num = '0;
    logic [15:0] flt_sub = '0;
    logic [1:0]  flt_cyc = 2'b11;
    logic        trouble_clr = 1'b0;
    logic        enter_fault;
    logic [4:0]  fault_num_q;
    logic [15:0] fault_sub_q;
    logic        fetch_flag;
    logic [2:0]  chan_num;
    logic [15:0] acv_flags;
    logic [15:0] fault_reg;
    logic [11:0] cycle_bits;
    logic [15:0] instr_cnt;
    logic        trouble_flag;
    logic        cascade_halt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int exp_low = 0;
    int exp_ic  = 0;

    always #4 clk = ~clk;

    fault_entry_seq dut_i (
        .clk(clk), .rst(rst), .flt_req(flt_req), .flt_num(flt_num), .flt_sub(flt_sub),
        .flt_cyc(flt_cyc), .trouble_clr(trouble_clr), .enter_fault(enter_fault),
        .fault_num_q(fault_num_q), .fault_sub_q(fault_sub_q), .fetch_flag(fetch_flag),
        .chan_num(chan_num), .acv_flags(acv_flags), .fault_reg(fault_reg),
        .cycle_bits(cycle_bits), .instr_cnt(instr_cnt), .trouble_flag(trouble_flag),
        .cascade_halt(cascade_halt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic fire(input logic [6:0] num, input logic [15:0] sub, input logic [1:0] cyc);
        @(negedge clk);
        flt_req = 1'b1; flt_num = num; flt_sub = sub; flt_cyc = cyc;
        @(negedge clk);
        flt_req = 1'b0; flt_cyc = 2'b11;
        exp_low = (exp_low + 1) % 8;
        if (cyc == 2'b01) exp_ic++;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 enter", 32'(enter_fault), 0);
        check("R1 num", 32'(fault_num_q), 0);
        check("R1 acv", 32'(acv_flags), 0);
        check("R1 freg", 32'(fault_reg), 0);
        check("R1 cycle_bits", 32'(cycle_bits), 32'hA50);
        check("R1 icnt", 32'(instr_cnt), 0);
        check("R1 flag/halt", {30'b0, trouble_flag, cascade_halt}, 0);
    endtask

    task automatic t_fetch_exec();
        fire(7'd5, 16'h1234, 2'b00);
        check("R2 in-range num", 32'(fault_num_q), 5);
        check("R5 fetch flag", 32'(fetch_flag), 1);
        check("R5 subtype", 32'(fault_sub_q), 32'h1234);
        check("R11 enter pulse", 32'(enter_fault), 1);
        check("R11 no count in fetch", 32'(instr_cnt), exp_ic);
        idle();
        check("R11 enter drops", 32'(enter_fault), 0);
        fire(7'd13, 16'h0001, 2'b01);
        check("R5 fetch flag clears", 32'(fetch_flag), 0);
        check("R11 exec counted", 32'(instr_cnt), exp_ic);
        check("R3 low bits", 32'(cycle_bits[2:0]), exp_low);
    endtask

    task automatic t_range();
        fire(7'h45, 16'h0, 2'b11);
        check("R2 bit6 clamps", 32'(fault_num_q), 31);
        fire(7'h20, 16'h0, 2'b11);
        check("R2 bit5 clamps", 32'(fault_num_q), 31);
    endtask

    task automatic t_acv();
        fire(7'd20, 16'hA5C3, 2'b11);
        check("R4 acv map", 32'(acv_flags), 32'hA5C3);
        fire(7'd3, 16'hFFFF, 2'b11);
        check("R4 acv cleared", 32'(acv_flags), 0);
    endtask

    task automatic t_connect();
        fire(7'd8, 16'hFFFD, 2'b11);
        check("R6 channel", 32'(chan_num), 5);
        fire(7'd9, 16'h0007, 2'b11);
        check("R6 channel zero", 32'(chan_num), 0);
    endtask

    task automatic t_illproc();
        fire(7'd10, 16'h0011, 2'b11);
        check("R10 first", 32'(fault_reg), 32'h0011);
        fire(7'd10, 16'h0300, 2'b11);
        check("R10 accumulate", 32'(fault_reg), 32'h0311);
        fire(7'd20, 16'h8000, 2'b11);
        check("R10 other keeps", 32'(fault_reg), 32'h0311);
    endtask

    task automatic t_nested();
        fire(7'd20, 16'h1234, 2'b10);
        check("R7 becomes trouble", 32'(fault_num_q), 31);
        check("R7 sub zero", 32'(fault_sub_q), 0);
        check("R7 no acv", 32'(acv_flags), 0);
        check("R7 flag set", 32'(trouble_flag), 1);
        check("R8 no halt first", 32'(cascade_halt), 0);
        fire(7'd8, 16'h0003, 2'b10);
        check("R8 halt on second", 32'(cascade_halt), 1);
        check("R7 no channel", 32'(chan_num), 0);
        idle();
        check("R8 halt one cycle", 32'(cascade_halt), 0);
        fire(7'd1, 16'h0, 2'b00);
        check("R9 plain fault clears", 32'(trouble_flag), 0);
    endtask

    task automatic t_clear();
        fire(7'd2, 16'h0, 2'b10);
        check("R9 flag before clear", 32'(trouble_flag), 1);
        @(negedge clk); trouble_clr = 1'b1;
        @(negedge clk); trouble_clr = 1'b0;
        check("R9 clr input", 32'(trouble_flag), 0);
        fire(7'd2, 16'h0, 2'b10);
        check("R8 no halt after clr", 32'(cascade_halt), 0);
        @(negedge clk);
        flt_req = 1'b1; flt_num = 7'd4; flt_cyc = 2'b10; trouble_clr = 1'b1;
        @(negedge clk);
        flt_req = 1'b0; trouble_clr = 1'b0; flt_cyc = 2'b11;
        exp_low = (exp_low + 1) % 8;
        check("R9 request beats clr", 32'(trouble_flag), 1);
        check("R8 halt with clr same edge", 32'(cascade_halt), 1);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 9; i++) begin
            fire(7'd6, 16'h0, 2'b01);
            check("R3 low wrap", 32'(cycle_bits[2:0]), exp_low);
        end
        check("R3 upper held", 32'(cycle_bits[11:3]), 32'(12'hA50 >> 3));
        check("R11 exec total", 32'(instr_cnt), exp_ic);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        idle();
        t_reset();
        t_fetch_exec();
        t_range();
        t_acv();
        t_connect();
        t_illproc();
        t_nested();
        t_clear();
        t_wrap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule